// File: doc/BRIEF.md
# Segmented Linear Address Generator

This block turns a 16-bit segment selector and a register-based effective address into a linear address. It is meant for a 16-bit segmented memory model. The effective offset is built from three parts: an optional base register, an optional index register and a 16-bit displacement. That offset is truncated to 16 bits. The segment base is the selector shifted left by four bits, and the offset is added to it. The sum is kept at 21 bits, so selector/offset pairs near the top of the map can reach the area just above one megabyte.

The register file contents arrive on input ports. Two small select fields choose which registers take part. A request strobe captures one computation. One cycle later the result appears on the outputs, together with a valid strobe and a flag that reports when the untruncated offset overran the fixed 64 KB segment limit. When the wrap-enable input is high, bit 20 of the result is cleared. This mimics a machine that has only twenty address lines. No paging or descriptor lookup is done: the output is used directly as the physical address.

Top module: `seg_addr_gen`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, vld, lin_addr and limit_fault are all zero.
- R2: vld is high in exactly the cycle after a cycle in which req was high at the rising clock edge, and low otherwise.
- R3: base_sel picks the base operand: 2'b00 gives zero, 2'b01 gives reg_bx, 2'b10 gives reg_bp, and 2'b11 gives zero.
- R4: idx_sel picks the index operand: 2'b00 gives zero, 2'b01 gives reg_si, 2'b10 gives reg_di, and 2'b11 gives zero.
- R5: With wrap_en low, lin_addr = seg_sel*16 + ((base + index + disp) mod 65536), computed at 21 bits.
- R6: With wrap_en low, results of 100000h and above are produced without truncation. The largest is 10FFEFh, reached with selector FFFFh and offset FFFFh.
- R7: With wrap_en high, lin_addr[20] is zero and lin_addr[19:0] equals the R5 value modulo 2^20.
- R8: limit_fault is high exactly when base + index + disp, before truncation, exceeds FFFFh.
- R9: In a cycle where req is low, lin_addr and limit_fault keep their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Capture a computation this cycle |
| wrap_en | input | 1 | Clear result bit 20 (1 MB wrap) |
| seg_sel | input | 16 | Segment selector |
| base_sel | input | 2 | Base register choice |
| idx_sel | input | 2 | Index register choice |
| reg_bx | input | 16 | First base register value |
| reg_bp | input | 16 | Second base register value |
| reg_si | input | 16 | First index register value |
| reg_di | input | 16 | Second index register value |
| disp | input | 16 | Displacement |
| vld | output | 1 | Result valid, one cycle after req |
| lin_addr | output | 21 | Linear address |
| limit_fault | output | 1 | Untruncated offset exceeded FFFFh |

## Verification
The properties assume that req, wrap_en and the select fields are settled at each rising edge. They also assume that reset is held for at least one edge before the first request. The bench changes every input only on falling edges and keeps req low during reset, so both assumptions hold. The range property on lin_addr relies on the selector and offset being at most 16 bits each. Because the ports carry exactly that width, the stimulus cannot go outside it, even when selectors and register values are set to all ones.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req,
  input  logic                           wrap_en,
  input  logic [OFS_W-1:0]               seg_sel,
  input  logic [1:0]                     base_sel,
  input  logic [1:0]                     idx_sel,
  input  logic [OFS_W-1:0]               reg_bx,
  input  logic [OFS_W-1:0]               reg_bp,
  input  logic [OFS_W-1:0]               reg_si,
  input  logic [OFS_W-1:0]               reg_di,
  input  logic [OFS_W-1:0]               disp,
  output logic                           vld,
  output logic [OFS_W+SEG_SHIFT:0]       lin_addr,
  output logic                           limit_fault
);
  localparam int LIN_W = OFS_W + SEG_SHIFT + 1;
  localparam int SUM_W = OFS_W + 2;

  logic [OFS_W-1:0] base_op, idx_op;
  logic [SUM_W-1:0] ofs_full;
  logic [LIN_W-1:0] seg_base, lin_raw, lin_next;

  always_comb begin
    case (base_sel)
      2'b01:   base_op = reg_bx;
      2'b10:   base_op = reg_bp;
      default: base_op = '0;
    endcase
    case (idx_sel)
      2'b01:   idx_op = reg_si;
      2'b10:   idx_op = reg_di;
      default: idx_op = '0;
    endcase
  end

  assign ofs_full = {2'b00, base_op} + {2'b00, idx_op} + {2'b00, disp};
  assign seg_base = {1'b0, seg_sel, {SEG_SHIFT{1'b0}}};
  assign lin_raw  = seg_base + {{(LIN_W-OFS_W){1'b0}}, ofs_full[OFS_W-1:0]};
  assign lin_next = wrap_en ? {1'b0, lin_raw[LIN_W-2:0]} : lin_raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld         <= 1'b0;
      lin_addr    <= '0;
      limit_fault <= 1'b0;
    end else begin
      vld <= req;
      if (req) begin
        lin_addr    <= lin_next;
        limit_fault <= |ofs_full[SUM_W-1:OFS_W];
      end
    end
  end
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req,
  input logic                     wrap_en,
  input logic [1:0]               base_sel,
  input logic [1:0]               idx_sel,
  input logic                     vld,
  input logic [OFS_W+SEG_SHIFT:0] lin_addr,
  input logic                     limit_fault
);
  localparam int LIN_W = OFS_W + SEG_SHIFT + 1;
  localparam logic [LIN_W-1:0] MAX_LIN =
    LIN_W'((((64'd1 << OFS_W) - 1) << SEG_SHIFT) + ((64'd1 << OFS_W) - 1));

  p_vld_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> vld);
  p_vld_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !vld);
  p_top_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && wrap_en) |=> !lin_addr[LIN_W-1]);
  p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> lin_addr <= MAX_LIN);
  p_disp_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && (base_sel == 2'b00) && (idx_sel == 2'b00)) |=> !limit_fault);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> ($stable(lin_addr) && $stable(limit_fault)));
endmodule

bind seg_addr_gen seg_addr_gen_chk #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) chk_i (.*);

// File: tb/seg_addr_gen_tb_top.sv
module seg_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wrap_en = 1'b0;
  logic [15:0] seg_sel = '0, reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0, disp = '0;
  logic [1:0]  base_sel = '0, idx_sel = '0;
  logic        vld, limit_fault;
  logic [20:0] lin_addr;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  seg_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .wrap_en(wrap_en), .seg_sel(seg_sel),
    .base_sel(base_sel), .idx_sel(idx_sel), .reg_bx(reg_bx), .reg_bp(reg_bp),
    .reg_si(reg_si), .reg_di(reg_di), .disp(disp), .vld(vld),
    .lin_addr(lin_addr), .limit_fault(limit_fault)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic longint pick_b(input logic [1:0] s);
    return (s == 2'd1) ? longint'(reg_bx) : (s == 2'd2) ? longint'(reg_bp) : 0;
  endfunction
  function automatic longint pick_i(input logic [1:0] s);
    return (s == 2'd1) ? longint'(reg_si) : (s == 2'd2) ? longint'(reg_di) : 0;
  endfunction

  task automatic run_one(input string tag);
    longint full, ea, exp;
    @(negedge clk);
    req = 1'b1;
    full = pick_b(base_sel) + pick_i(idx_sel) + longint'(disp);
    ea   = full % 65536;
    exp  = longint'(seg_sel) * 16 + ea;
    if (wrap_en) exp = exp % (1 << 20);
    @(negedge clk);
    req = 1'b0;
    chk("R2 vld", longint'(vld), 1);
    chk(tag, longint'(lin_addr), exp);
    chk("R8 fault", longint'(limit_fault), (full > 65535) ? 1 : 0);
    seg_sel = ~seg_sel; disp = disp ^ 16'h5A5A; wrap_en = ~wrap_en;
    @(negedge clk);
    chk("R2 vld low", longint'(vld), 0);
    chk("R9 hold addr", longint'(lin_addr), exp);
    chk("R9 hold fault", longint'(limit_fault), (full > 65535) ? 1 : 0);
    seg_sel = ~seg_sel; disp = disp ^ 16'h5A5A; wrap_en = ~wrap_en;
  endtask

  initial begin
    logic [15:0] sels [6] = '{16'h0000, 16'h0001, 16'h1234, 16'h8000, 16'hF000, 16'hFFFF};
    logic [15:0] disps[4] = '{16'h0000, 16'h0010, 16'h8001, 16'hFFFF};
    repeat (3) @(negedge clk);
    chk("R1 vld", longint'(vld), 0);
    chk("R1 addr", longint'(lin_addr), 0);
    chk("R1 fault", longint'(limit_fault), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post vld", longint'(vld), 0);
    chk("R1 post addr", longint'(lin_addr), 0);

    reg_bx = 16'h1111; reg_bp = 16'h2222; reg_si = 16'h0400; reg_di = 16'h0080;
    for (int b = 0; b < 4; b++) begin
      base_sel = 2'(b); idx_sel = 2'b00;
      run_one("R3 base select");
    end
    for (int i = 0; i < 4; i++) begin
      base_sel = 2'b00; idx_sel = 2'(i);
      run_one("R4 index select");
    end

    seg_sel = 16'hFFFF; base_sel = 2'b01; idx_sel = 2'b00; disp = 16'h0000; reg_bx = 16'hFFFF;
    wrap_en = 1'b0;
    run_one("R6 top of map");
    chk("R6 value", longint'(lin_addr), 64'h10FFEF);
    wrap_en = 1'b1;
    run_one("R7 wrap");
    chk("R7 value", longint'(lin_addr), 64'h0FFEF);

    for (int rs = 0; rs < 3; rs++) begin
      case (rs)
        0: begin reg_bx = 16'h0001; reg_bp = 16'h7FFF; reg_si = 16'h0002; reg_di = 16'h8000; end
        1: begin reg_bx = 16'hFFFF; reg_bp = 16'hFFFE; reg_si = 16'hFFFF; reg_di = 16'h0100; end
        default: begin reg_bx = 16'hABCD; reg_bp = 16'h0000; reg_si = 16'h4321; reg_di = 16'hF00F; end
      endcase
      foreach (sels[s]) foreach (disps[d])
        for (int c = 0; c < 16; c++)
          for (int w = 0; w < 2; w++) begin
            seg_sel = sels[s]; disp = disps[d];
            base_sel = 2'(c >> 2); idx_sel = 2'(c & 3); wrap_en = w[0];
            run_one(w[0] ? "R7 wrapped addr" : "R5 addr");
          end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule